// File: doc/BRIEF.md
# Programmable Carrier Frequency Divider

This block turns a fast reference clock into the antenna carrier for a full-bridge output stage. It counts reference cycles and drives a pair of complementary bridge signals, one per half of each carrier period. The number of reference cycles in one period, called the division factor, comes from a 4-bit selection code held in a mode register elsewhere. Most codes pick a fixed factor. One code picks an automatic mode in which the factor is a count from a resonance measurement made by another block. That count is used only when it is flagged valid and lies in the legal range.

A new factor never cuts a period short. The divider reads the requested factor only at the boundary between two carrier periods. The carrier-enable input gates the stage for full-depth amplitude modulation. While it is low, both bridge legs are held low. When it returns high, the carrier restarts with a complete period.

Top module: `carrier_div`

## Requirements
- R1: Selection code 0 (binary 0000) gives a division factor of 119 reference cycles per carrier period.
- R2: Selection codes 1 to 11 give a factor of 113 plus the code, so code 1 gives 114, code 2 gives 115, code 6 gives 119 and code 11 gives 124.
- R3: Selection code 15 (binary 1111) with the measurement-valid flag high and a measured count from 114 to 124 gives a factor equal to the measured count.
- R4: Selection code 15 with the valid flag low, or with a measured count below 114 or above 124, gives a factor of 119.
- R5: Selection codes 12, 13 and 14 give a factor of 119.
- R6: A change of the selection code, or of the automatic-mode inputs, during a carrier period does not alter that period. The new factor governs the periods that start after the period in progress ends.
- R7: Each carrier period of factor F begins with `drv_a` high for ceil(F/2) reference cycles, followed by `drv_b` high for floor(F/2) cycles.
- R8: While carrier-enable was high at the last clock edge, exactly one of `drv_a` and `drv_b` is high.
- R9: While carrier-enable was low at the last clock edge, both outputs are low. When enable returns high, the carrier starts from the beginning of a full period, with `drv_a` high from the first enabled edge.
- R10: During reset and directly after it, with enable low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that the divider counts |
| rst | input | 1 | Synchronous reset, active high |
| sel_code | input | 4 | Division-factor selection code from the mode register |
| meas_cnt | input | 8 | Resonance-measurement count used in automatic mode |
| meas_vld | input | 1 | High when `meas_cnt` holds a finished measurement |
| carrier_en | input | 1 | Carrier gate; low forces both bridge legs low |
| drv_a | output | 1 | Bridge leg A drive, high in the first half of a period |
| drv_b | output | 1 | Bridge leg B drive, high in the second half of a period |

## Verification
The period counter, the active factor and the run flag are not visible at the ports. A fault in any of them shows up as a change in the length of a high or low phase of `drv_a`.
- A wrong factor, or a factor taken mid-period, gives a wrong phase length. This appears no later than the end of the affected carrier period, so at most 124 reference cycles after the fault.
- A counter that does not restart after the enable gate gives a short first period. This appears within one period of re-enabling.
- A broken gate or broken complement logic gives both legs equal. This appears on the very next reference cycle.

The bench measures every complete period, so each of these faults is caught in that time frame.

// File: rtl/carrier_div_pkg.sv
`timescale 1ns/1ps
package carrier_div_pkg;

   // How a selection code was resolved by the code map
   typedef enum logic [1:0] {
      MAP_FIXED    = 2'd0,   // factor comes straight from the code
      MAP_AUTO     = 2'd1,   // factor comes from the resonance measurement
      MAP_FALLBACK = 2'd2    // default factor
   } map_kind_e;

endpackage

// File: rtl/cdiv_code_map.sv
`timescale 1ns/1ps
module cdiv_code_map
   import carrier_div_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter int DIV_W     = 7,
   parameter int DIV_DEF   = 119,
   parameter int CODE_OFS  = 113,
   parameter int CODE_LAST = 11,
   parameter int CODE_AUTO = 15
) (
   input  logic [CODE_W-1:0] code,
   output map_kind_e         kind,
   output logic [DIV_W-1:0]  fixed_div
);

   localparam logic [CODE_W-1:0] LAST_C = CODE_W'(CODE_LAST);
   localparam logic [CODE_W-1:0] AUTO_C = CODE_W'(CODE_AUTO);
   localparam logic [DIV_W-1:0]  DEF_F  = DIV_W'(DIV_DEF);
   localparam logic [DIV_W-1:0]  OFS_F  = DIV_W'(CODE_OFS);

   always_comb begin
      kind      = MAP_FALLBACK;
      fixed_div = DEF_F;
      if (code == '0) begin
         kind      = MAP_FALLBACK;
         fixed_div = DEF_F;
      end else if (code <= LAST_C) begin
         kind      = MAP_FIXED;
         fixed_div = OFS_F + DIV_W'(code);
      end else if (code == AUTO_C) begin
         kind      = MAP_AUTO;
         fixed_div = DEF_F;
      end
   end

endmodule

// File: rtl/cdiv_auto_pick.sv
`timescale 1ns/1ps
module cdiv_auto_pick
   import carrier_div_pkg::*;
#(
   parameter bit AUTO_EN = 1'b1,
   parameter int MEAS_W  = 8,
   parameter int DIV_W   = 7,
   parameter int DIV_MIN = 114,
   parameter int DIV_MAX = 124,
   parameter int DIV_DEF = 119
) (
   input  map_kind_e         kind,
   input  logic [DIV_W-1:0]  fixed_div,
   input  logic [MEAS_W-1:0] meas_cnt,
   input  logic              meas_vld,
   output logic [DIV_W-1:0]  req_div
);

   localparam logic [DIV_W-1:0]  DEF_F = DIV_W'(DIV_DEF);
   localparam logic [MEAS_W-1:0] LO_M  = MEAS_W'(DIV_MIN);
   localparam logic [MEAS_W-1:0] HI_M  = MEAS_W'(DIV_MAX);

   generate
      if (AUTO_EN) begin : g_auto
         logic meas_ok;
         always_comb begin
            meas_ok = meas_vld && (meas_cnt >= LO_M) && (meas_cnt <= HI_M);
            if (kind == MAP_AUTO)
               req_div = meas_ok ? DIV_W'(meas_cnt) : DEF_F;
            else if (kind == MAP_FIXED)
               req_div = fixed_div;
            else
               req_div = DEF_F;
         end
      end else begin : g_fixed_only
         always_comb begin
            req_div = (kind == MAP_FIXED) ? fixed_div : DEF_F;
         end
      end
   endgenerate

endmodule

// File: rtl/cdiv_period_gen.sv
`timescale 1ns/1ps
module cdiv_period_gen #(
   parameter int DIV_W   = 7,
   parameter int DIV_RST = 119
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DIV_W-1:0] req_div,
   output logic             drv_a,
   output logic             drv_b,
   output logic [DIV_W-1:0] cur_div,
   output logic             period_start
);

   logic [DIV_W-1:0] cnt_q, cnt_d;
   logic [DIV_W-1:0] div_q, div_d;
   logic [DIV_W-1:0] half_d;
   logic             run_q, run_d;
   logic             a_q, b_q;
   logic             first_half;

   always_comb begin
      run_d = run_q;
      cnt_d = cnt_q;
      div_d = div_q;
      if (!en) begin
         run_d = 1'b0;
         cnt_d = '0;
         div_d = req_div;
      end else if (!run_q) begin
         run_d = 1'b1;
         cnt_d = '0;
         div_d = req_div;
      end else if (cnt_q == div_q - 1'b1) begin
         cnt_d = '0;
         div_d = req_div;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
      half_d     = (div_d + 1'b1) >> 1;
      first_half = cnt_d < half_d;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         div_q <= DIV_W'(DIV_RST);
         a_q   <= 1'b0;
         b_q   <= 1'b0;
      end else begin
         run_q <= run_d;
         cnt_q <= cnt_d;
         div_q <= div_d;
         a_q   <= run_d &&  first_half;
         b_q   <= run_d && !first_half;
      end
   end

   assign drv_a        = a_q;
   assign drv_b        = b_q;
   assign cur_div      = div_q;
   assign period_start = run_q && (cnt_q == '0);

endmodule

// File: rtl/carrier_div.sv
`timescale 1ns/1ps
module carrier_div
   import carrier_div_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter int MEAS_W    = 8,
   parameter int DIV_MIN   = 114,
   parameter int DIV_MAX   = 124,
   parameter int DIV_DEF   = 119,
   parameter int CODE_OFS  = 113,
   parameter int CODE_LAST = 11,
   parameter int CODE_AUTO = 15,
   parameter bit AUTO_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] sel_code,
   input  logic [MEAS_W-1:0] meas_cnt,
   input  logic              meas_vld,
   input  logic              carrier_en,
   output logic              drv_a,
   output logic              drv_b
);

   localparam int DIV_W = $clog2(DIV_MAX + 2);

   generate
      if (DIV_MIN < 2 || DIV_MIN > DIV_MAX) begin : g_bad_range
         $error("carrier_div: factor range is empty or too small");
      end
      if (DIV_DEF < DIV_MIN || DIV_DEF > DIV_MAX) begin : g_bad_def
         $error("carrier_div: default factor outside range");
      end
      if (CODE_OFS + 1 < DIV_MIN || CODE_OFS + CODE_LAST > DIV_MAX) begin : g_bad_map
         $error("carrier_div: code map leaves the factor range");
      end
      if (CODE_AUTO <= CODE_LAST || CODE_AUTO >= (1 << CODE_W)) begin : g_bad_auto
         $error("carrier_div: automatic code collides or does not fit");
      end
      if (DIV_MAX >= (1 << MEAS_W)) begin : g_bad_meas
         $error("carrier_div: measurement width too small");
      end
   endgenerate

   map_kind_e        map_kind;
   logic [DIV_W-1:0] fixed_div;
   logic [DIV_W-1:0] req_div;
   logic [DIV_W-1:0] cur_div;
   logic             period_start;

   cdiv_code_map #(
      .CODE_W   (CODE_W),
      .DIV_W    (DIV_W),
      .DIV_DEF  (DIV_DEF),
      .CODE_OFS (CODE_OFS),
      .CODE_LAST(CODE_LAST),
      .CODE_AUTO(CODE_AUTO)
   ) u_map (
      .code     (sel_code),
      .kind     (map_kind),
      .fixed_div(fixed_div)
   );

   cdiv_auto_pick #(
      .AUTO_EN(AUTO_EN),
      .MEAS_W (MEAS_W),
      .DIV_W  (DIV_W),
      .DIV_MIN(DIV_MIN),
      .DIV_MAX(DIV_MAX),
      .DIV_DEF(DIV_DEF)
   ) u_pick (
      .kind     (map_kind),
      .fixed_div(fixed_div),
      .meas_cnt (meas_cnt),
      .meas_vld (meas_vld),
      .req_div  (req_div)
   );

   cdiv_period_gen #(
      .DIV_W  (DIV_W),
      .DIV_RST(DIV_DEF)
   ) u_gen (
      .clk         (clk),
      .rst         (rst),
      .en          (carrier_en),
      .req_div     (req_div),
      .drv_a       (drv_a),
      .drv_b       (drv_b),
      .cur_div     (cur_div),
      .period_start(period_start)
   );

endmodule

// File: rtl/carrier_div_chk.sv
`timescale 1ns/1ps
module carrier_div_chk #(
   parameter int DIV_W   = 7,
   parameter int DIV_MIN = 114,
   parameter int DIV_MAX = 124
) (
   input logic             clk,
   input logic             rst,
   input logic             carrier_en,
   input logic             drv_a,
   input logic             drv_b,
   input logic [DIV_W-1:0] cur_div,
   input logic             period_start
);

   AST_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
      !carrier_en |=> (!drv_a && !drv_b)) else $error("gate"); // R9

   AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      carrier_en |=> (drv_a ^ drv_b)) else $error("complement"); // R8

   AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
      ((drv_a || drv_b) && !period_start) |-> $stable(cur_div)) else $error("hold"); // R6

   AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
      period_start |-> (drv_a && !drv_b)) else $error("phase order"); // R7

   AST_FACTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
      (drv_a || drv_b) |-> (cur_div >= DIV_W'(DIV_MIN) && cur_div <= DIV_W'(DIV_MAX)))
      else $error("range"); // R4

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!drv_a && !drv_b)) else $error("reset"); // R10

endmodule

bind carrier_div carrier_div_chk #(
   .DIV_W  (DIV_W),
   .DIV_MIN(DIV_MIN),
   .DIV_MAX(DIV_MAX)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .carrier_en  (carrier_en),
   .drv_a       (drv_a),
   .drv_b       (drv_b),
   .cur_div     (cur_div),
   .period_start(period_start)
);

// File: tb/carrier_div_test.sv
`timescale 1ns/1ps
module carrier_div_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sel_code = 4'd0;
   logic [7:0] meas_cnt = 8'd0;
   logic       meas_vld = 1'b0;
   logic       carrier_en = 1'b0;
   logic       drv_a, drv_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int    exp_hi_q[$];
   int    exp_lo_q[$];
   string exp_tag_q[$];

   always #10 clk = ~clk;

   carrier_div uut (
      .clk       (clk),
      .rst       (rst),
      .sel_code  (sel_code),
      .meas_cnt  (meas_cnt),
      .meas_vld  (meas_vld),
      .carrier_en(carrier_en),
      .drv_a     (drv_a),
      .drv_b     (drv_b)
   );

   task automatic push_periods(input int n, input int f, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_hi_q.push_back((f + 1) / 2);
         exp_lo_q.push_back(f / 2);
         exp_tag_q.push_back(tag);
      end
   endtask

   task automatic check_drained(input string tag);
      checks++;
      if (exp_hi_q.size() != 0) begin
         errors++;
         $display("FAIL %s periods left unobserved: actual %0d expected 0", tag, exp_hi_q.size());
         exp_hi_q.delete();
         exp_lo_q.delete();
         exp_tag_q.delete();
      end
   endtask

   // Program the inputs while gated, then run n complete periods of factor f
   task automatic run_case(input logic [3:0] code, input logic vld, input logic [7:0] meas,
                           input int n, input int f, input string tag);
      @(negedge clk);
      carrier_en = 1'b0;
      sel_code   = code;
      meas_vld   = vld;
      meas_cnt   = meas;
      repeat (3) @(negedge clk);
      push_periods(n, f, tag);
      carrier_en = 1'b1;
      repeat (n * f + 2) @(negedge clk);
      carrier_en = 1'b0;
      repeat (3) @(negedge clk);
      check_drained(tag);
   endtask

   // Monitor: per-cycle gate checks and period measurement
   int hi_cnt = 0;
   int lo_cnt = 0;
   bit started = 1'b0;
   bit prev_a = 1'b0;

   always begin
      @(posedge clk);
      #5;
      if (!rst && !done) begin
         checks++;
         if (!carrier_en && (drv_a || drv_b)) begin
            errors++;
            $display("FAIL R9 gated outputs: actual a=%0b b=%0b expected a=0 b=0", drv_a, drv_b);
         end else if (carrier_en && (drv_a == drv_b)) begin
            errors++;
            $display("FAIL R8 complement: actual a=%0b b=%0b expected opposite", drv_a, drv_b);
         end
         if (!drv_a && !drv_b) begin
            started = 1'b0;
         end else if (drv_a && !prev_a) begin
            if (started) begin
               checks++;
               if (exp_hi_q.size() == 0) begin
                  errors++;
                  $display("FAIL R7 unexpected period: actual hi=%0d lo=%0d expected none", hi_cnt, lo_cnt);
               end else begin
                  int    eh;
                  int    el;
                  string et;
                  eh = exp_hi_q.pop_front();
                  el = exp_lo_q.pop_front();
                  et = exp_tag_q.pop_front();
                  if (eh != hi_cnt || el != lo_cnt) begin
                     errors++;
                     $display("FAIL %s period: actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                              et, hi_cnt, lo_cnt, eh, el);
                  end
               end
            end
            started = 1'b1;
            hi_cnt  = 1;
            lo_cnt  = 0;
         end else if (drv_a) begin
            hi_cnt++;
         end else begin
            lo_cnt++;
         end
         prev_a = drv_a;
      end else begin
         started = 1'b0;
         prev_a  = 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10: outputs low in reset even with the gate open
      carrier_en = 1'b1;
      repeat (4) @(negedge clk);
      checks++;
      if (drv_a || drv_b) begin
         errors++;
         $display("FAIL R10 in reset: actual a=%0b b=%0b expected 0 0", drv_a, drv_b);
      end
      carrier_en = 1'b0;
      rst = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (drv_a || drv_b) begin
         errors++;
         $display("FAIL R10 after reset: actual a=%0b b=%0b expected 0 0", drv_a, drv_b);
      end

      run_case(4'd0,  1'b0, 8'd0,   2, 119, "R1");
      run_case(4'd1,  1'b0, 8'd0,   2, 114, "R2");
      run_case(4'd2,  1'b0, 8'd0,   2, 115, "R2");
      run_case(4'd6,  1'b0, 8'd0,   2, 119, "R2");
      run_case(4'd11, 1'b0, 8'd0,   2, 124, "R2");
      run_case(4'd12, 1'b0, 8'd0,   2, 119, "R5");
      run_case(4'd13, 1'b1, 8'd121, 1, 119, "R5");
      run_case(4'd14, 1'b0, 8'd0,   1, 119, "R5");
      run_case(4'd15, 1'b1, 8'd121, 2, 121, "R3");
      run_case(4'd15, 1'b1, 8'd114, 1, 114, "R3");
      run_case(4'd15, 1'b1, 8'd124, 1, 124, "R3");
      run_case(4'd15, 1'b0, 8'd121, 1, 119, "R4");
      run_case(4'd15, 1'b1, 8'd113, 1, 119, "R4");
      run_case(4'd15, 1'b1, 8'd125, 1, 119, "R4");
      run_case(4'd15, 1'b1, 8'd200, 1, 119, "R4");

      // R6: code changes inside the third period of factor 114
      @(negedge clk);
      sel_code = 4'd1;
      meas_vld = 1'b0;
      repeat (3) @(negedge clk);
      push_periods(3, 114, "R6");
      push_periods(3, 124, "R6");
      carrier_en = 1'b1;
      repeat (2 * 114 + 30) @(negedge clk);
      sel_code = 4'd11;
      repeat (114 - 30 + 3 * 124 + 2) @(negedge clk);
      carrier_en = 1'b0;
      repeat (3) @(negedge clk);
      check_drained("R6");

      // R6: automatic count changes mid-period
      @(negedge clk);
      sel_code = 4'd15;
      meas_vld = 1'b1;
      meas_cnt = 8'd117;
      repeat (3) @(negedge clk);
      push_periods(2, 117, "R6");
      push_periods(1, 122, "R6");
      carrier_en = 1'b1;
      repeat (117 + 50) @(negedge clk);
      meas_cnt = 8'd122;
      repeat (117 - 50 + 122 + 2) @(negedge clk);
      carrier_en = 1'b0;
      repeat (3) @(negedge clk);
      check_drained("R6");

      // R9: gate drops in mid high phase; restart must give a full period
      @(negedge clk);
      sel_code = 4'd2;
      meas_vld = 1'b0;
      carrier_en = 1'b1;
      repeat (30) @(negedge clk);
      carrier_en = 1'b0;
      @(negedge clk);
      push_periods(2, 115, "R9");
      carrier_en = 1'b1;
      repeat (2 * 115 + 2) @(negedge clk);
      carrier_en = 1'b0;
      repeat (3) @(negedge clk);
      check_drained("R9");

      done = 1'b1;
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule